// File: doc/BRIEF.md
# Clock Root Configuration Registers

This block is the software-facing register file of a clock root. Software programs the source select, the pre-divider, the divider mode and the three fractional-divider values through a simple word-addressed bus. Every write lands in a shadow copy only. The values that drive the divider datapath change in one step, and only when software asks for it through the update bit in the command register.

The update bit stays set while the commit is in progress. It clears on its own once the active copy has taken the shadow values, so software polls it to learn when the new setting is live. Four dirty flags show which shadow registers hold a value that differs from the active one.

The command register also has a force-enable bit. That bit is ORed with an external enable request. The result passes through a two-stage synchronizer and is reported both as a running indication and as an inverted root-off status bit.

Top module: `clk_root_cfg_regs`

## Requirements
- R1: After reset, all shadow and active values are zero, and so are the force-enable, update and dirty bits. The command register reads 0x8000_0000, provided the external enable is low.
- R2: Register offsets are as follows: command at 0x00, config at 0x04, M at 0x08, N at 0x0C and D at 0x10. The config register reads back its shadow with the pre-divider in bits HID_W-1:0, the source select in bits 10:8 and the mode in bits 13:12. M, N and D read back only their low MND_W bits. All other bits read 0.
- R3: Shadow writes do not change the active outputs until a commit.
- R4: Writing 1 to command bit 0 makes that bit read 1 for exactly COMMIT_CYC cycles after the write edge, and it then reads 0. At that edge the active outputs take the current shadow values, including shadow writes made while the commit was pending. Writing 0 to bit 0 starts nothing.
- R5: The dirty flags are command bit 4 (config), bit 5 (N), bit 6 (M) and bit 7 (D). A flag sets when a write leaves its shadow different from the active value. A write equal to the active value leaves the flag unchanged. A commit clears all four flags.
- R6: Command bit 1 is a read/write force-enable bit.
- R7: root_on_o equals (force-enable OR ext_en_i) delayed by two clock edges. Command bit 31 reads the inverse of root_on_o.
- R8: Writes to command bits other than 0 and 1 have no effect.
- R9: Reads of an unmapped offset return 0, and writes to an unmapped offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational, zero when no read) |
| ext_en_i | input | 1 | External root enable request |
| root_on_o | output | 1 | Synchronized root running indication |
| act_div_o | output | HID_W | Active pre-divider |
| act_src_o | output | 3 | Active source select |
| act_mode_o | output | 2 | Active divider mode |
| act_m_o | output | MND_W | Active M value |
| act_n_o | output | MND_W | Active N value |
| act_d_o | output | MND_W | Active D value |

## Verification
The hardest case to reach is a shadow write that lands inside the commit window. The outcome depends on which value is in the shadow at the exact commit edge. To reach it, the bench issues the update request and then, on the very next cycle, writes a new M value. It then checks that the second value, not the first, reaches the active output. The bench also reads the update bit on every cycle after the request, counting cycles from the request edge, to confirm that the window is exactly COMMIT_CYC cycles long.

// File: rtl/clk_root_pkg.sv
package clk_root_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_CMD = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CFG = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_M   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_N   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_D   = 5'h10;

  localparam int CMD_UPD      = 0;
  localparam int CMD_FORCE    = 1;
  localparam int CMD_DIRTY_LO = 4;
  localparam int CMD_ROOT_OFF = 31;

  localparam int CFG_SRC_LSB  = 8;
  localparam int CFG_SRC_W    = 3;
  localparam int CFG_MODE_LSB = 12;
  localparam int CFG_MODE_W   = 2;

  // dirty flag index, order fixed by command bit positions
  typedef enum logic [1:0] {FLD_CFG = 2'd0, FLD_N = 2'd1, FLD_M = 2'd2, FLD_D = 2'd3} fld_e;
endpackage

// File: rtl/clk_root_shadow_reg.sv
module clk_root_shadow_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         commit_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o,
  output logic         dirty_o
);
  logic [W-1:0] act_nxt;
  logic         dirty_keep;

  assign act_nxt    = commit_i ? shadow_o : active_o;
  assign dirty_keep = commit_i ? 1'b0 : dirty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
      active_o <= '0;
      dirty_o  <= 1'b0;
    end else begin
      active_o <= act_nxt;
      if (wr_i) shadow_o <= wdata_i;
      // a write in the commit cycle is compared with the value being committed
      dirty_o <= wr_i ? (dirty_keep | (wdata_i != act_nxt)) : dirty_keep;
    end
  end
endmodule

// File: rtl/clk_root_commit_ctrl.sv
module clk_root_commit_ctrl #(
  parameter int COMMIT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pend_o,
  output logic commit_o
);
  localparam int CNT_W = $clog2(COMMIT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign commit_o = pend_o && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!pend_o) begin
      if (start_i) begin
        pend_o <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (commit_o) begin
      pend_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clk_root_sync2.sv
module clk_root_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      q_o  <= 1'b0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/clk_root_cfg_regs.sv
module clk_root_cfg_regs
  import clk_root_pkg::*;
#(
  parameter int HID_W      = 5,
  parameter int MND_W      = 8,
  parameter int COMMIT_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              ext_en_i,
  output logic              root_on_o,
  output logic [HID_W-1:0]  act_div_o,
  output logic [2:0]        act_src_o,
  output logic [1:0]        act_mode_o,
  output logic [MND_W-1:0]  act_m_o,
  output logic [MND_W-1:0]  act_n_o,
  output logic [MND_W-1:0]  act_d_o
);
  // config is stored packed as {mode, src, div}
  localparam int CFG_W  = CFG_MODE_W + CFG_SRC_W + HID_W;
  localparam int N_MND  = 3;
  localparam logic [ADDR_W-1:0] MND_OFF [N_MND] = '{OFF_N, OFF_M, OFF_D};

  logic             bus_wr, bus_rd;
  logic             upd_pend, commit, upd_start;
  logic             force_en, root_req;
  logic [3:0]       dirty;
  logic             shadow_wr;
  logic [N_MND-1:0] mnd_wr;
  logic             cfg_wr;
  logic [CFG_W-1:0] cfg_wval, cfg_shadow, cfg_active;
  logic [MND_W-1:0] mnd_shadow [N_MND];
  logic [MND_W-1:0] mnd_active [N_MND];

  assign bus_wr = req_i && we_i;
  assign bus_rd = req_i && !we_i;

  assign upd_start = bus_wr && (addr_i == OFF_CMD) && wdata_i[CMD_UPD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             force_en <= 1'b0;
    else if (bus_wr && (addr_i == OFF_CMD)) force_en <= wdata_i[CMD_FORCE];
  end

  clk_root_commit_ctrl #(.COMMIT_CYC(COMMIT_CYC)) u_commit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (upd_start),
    .pend_o   (upd_pend),
    .commit_o (commit)
  );

  assign cfg_wr   = bus_wr && (addr_i == OFF_CFG);
  assign cfg_wval = {wdata_i[CFG_MODE_LSB +: CFG_MODE_W],
                     wdata_i[CFG_SRC_LSB +: CFG_SRC_W],
                     wdata_i[HID_W-1:0]};

  clk_root_shadow_reg #(.W(CFG_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr),
    .wdata_i  (cfg_wval),
    .commit_i (commit),
    .shadow_o (cfg_shadow),
    .active_o (cfg_active),
    .dirty_o  (dirty[FLD_CFG])
  );

  for (genvar g = 0; g < N_MND; g++) begin : g_mnd
    assign mnd_wr[g] = bus_wr && (addr_i == MND_OFF[g]);
    clk_root_shadow_reg #(.W(MND_W)) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (mnd_wr[g]),
      .wdata_i  (wdata_i[MND_W-1:0]),
      .commit_i (commit),
      .shadow_o (mnd_shadow[g]),
      .active_o (mnd_active[g]),
      .dirty_o  (dirty[g+1])
    );
  end

  assign shadow_wr = cfg_wr || (|mnd_wr);

  assign root_req = force_en || ext_en_i;

  clk_root_sync2 u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (root_req),
    .q_o    (root_on_o)
  );

  assign act_div_o  = cfg_active[HID_W-1:0];
  assign act_src_o  = cfg_active[HID_W +: CFG_SRC_W];
  assign act_mode_o = cfg_active[HID_W+CFG_SRC_W +: CFG_MODE_W];
  assign act_n_o    = mnd_active[0];
  assign act_m_o    = mnd_active[1];
  assign act_d_o    = mnd_active[2];

  always_comb begin
    rdata_o = '0;
    if (bus_rd) begin
      case (addr_i)
        OFF_CMD: begin
          rdata_o[CMD_UPD]                 = upd_pend;
          rdata_o[CMD_FORCE]               = force_en;
          rdata_o[CMD_DIRTY_LO +: 4]       = dirty;
          rdata_o[CMD_ROOT_OFF]            = ~root_on_o;
        end
        OFF_CFG: begin
          rdata_o[HID_W-1:0]               = cfg_shadow[HID_W-1:0];
          rdata_o[CFG_SRC_LSB +: CFG_SRC_W]   = cfg_shadow[HID_W +: CFG_SRC_W];
          rdata_o[CFG_MODE_LSB +: CFG_MODE_W] = cfg_shadow[HID_W+CFG_SRC_W +: CFG_MODE_W];
        end
        OFF_N:   rdata_o[MND_W-1:0] = mnd_shadow[0];
        OFF_M:   rdata_o[MND_W-1:0] = mnd_shadow[1];
        OFF_D:   rdata_o[MND_W-1:0] = mnd_shadow[2];
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/clk_root_cfg_chk.sv
module clk_root_cfg_chk #(
  parameter int HID_W      = 5,
  parameter int MND_W      = 8,
  parameter int COMMIT_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [4:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             upd_pend,
  input logic             commit,
  input logic             shadow_wr,
  input logic [3:0]       dirty,
  input logic             root_req,
  input logic             root_on_o,
  input logic [HID_W-1:0] act_div_o,
  input logic [2:0]       act_src_o,
  input logic [1:0]       act_mode_o,
  input logic [MND_W-1:0] act_m_o,
  input logic [MND_W-1:0] act_n_o,
  input logic [MND_W-1:0] act_d_o
);
  localparam int PW = $clog2(COMMIT_CYC + 2);

  logic [PW-1:0] pend_cnt;
  logic [1:0]    since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_cnt  <= '0;
      since_rst <= '0;
    end else begin
      pend_cnt  <= upd_pend ? pend_cnt + 1'b1 : '0;
      if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end
  end

  AST_UPD_WINDOW_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_pend |-> (pend_cnt < PW'(COMMIT_CYC))); // R4

  AST_UPD_WINDOW_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(upd_pend) |-> ($past(pend_cnt) == PW'(COMMIT_CYC - 1))); // R4

  AST_UPD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 5'h00 && wdata_i[0] && !commit) |=> upd_pend); // R4

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> ($stable(act_div_o) && $stable(act_src_o) && $stable(act_mode_o)
                 && $stable(act_m_o) && $stable(act_n_o) && $stable(act_d_o))); // R3

  AST_DIRTY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !shadow_wr) |=> (dirty == 4'b0)); // R5

  AST_ROOT_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2) |-> (root_on_o == $past(root_req, 2))); // R7

  AST_ROOT_OFF_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 5'h00) |-> (rdata_o[31] == !root_on_o)); // R7
endmodule

bind clk_root_cfg_regs clk_root_cfg_chk #(
  .HID_W(HID_W), .MND_W(MND_W), .COMMIT_CYC(COMMIT_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .upd_pend   (upd_pend),
  .commit     (commit),
  .shadow_wr  (shadow_wr),
  .dirty      (dirty),
  .root_req   (root_req),
  .root_on_o  (root_on_o),
  .act_div_o  (act_div_o),
  .act_src_o  (act_src_o),
  .act_mode_o (act_mode_o),
  .act_m_o    (act_m_o),
  .act_n_o    (act_n_o),
  .act_d_o    (act_d_o)
);

// File: tb/clk_root_cfg_regs_tb.sv
module clk_root_cfg_regs_tb;
  localparam int HID_W = 5;
  localparam int MND_W = 8;
  localparam int NVEC  = 6;
  // {addr[4:0], wdata[31:0], expected readback[31:0]}
  localparam logic [68:0] VEC [NVEC] = '{
    {5'h04, 32'hFFFF_FFFF, 32'h0000_371F},
    {5'h04, 32'h0000_2305, 32'h0000_2305},
    {5'h08, 32'h0000_1234, 32'h0000_0034},
    {5'h0C, 32'h0000_ABCD, 32'h0000_00CD},
    {5'h10, 32'hFFFF_FF00, 32'h0000_0000},
    {5'h14, 32'hDEAD_BEEF, 32'h0000_0000}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, ext_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        root_on_o;
  logic [HID_W-1:0] act_div_o;
  logic [2:0]  act_src_o;
  logic [1:0]  act_mode_o;
  logic [MND_W-1:0] act_m_o, act_n_o, act_d_o;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2 clk_i = ~clk_i;

  clk_root_cfg_regs #(.HID_W(HID_W), .MND_W(MND_W), .COMMIT_CYC(4)) u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .ext_en_i, .root_on_o, .act_div_o, .act_src_o, .act_mode_o,
    .act_m_o, .act_n_o, .act_d_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  // samples state at current negedge, then advances one cycle
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic poll_upd(output int cnt);
    logic [31:0] v;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      rd(5'h00, v);
      if (!v[0]) break;
      cnt++;
    end
  endtask

  function automatic logic [31:0] acts();
    return {act_mode_o, act_src_o, act_div_o, act_m_o, act_n_o, act_d_o};
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int c;
    do_reset();
    // R1 reset state
    rd(5'h00, v); chk("R1 cmd after reset", v, 32'h8000_0000);
    rd(5'h04, v); chk("R1 cfg after reset", v, 32'h0);
    chk("R1 actives after reset", acts(), 32'h0);

    // R2 / R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      chk((VEC[i][68:64] == 5'h14) ? "R9 unmapped" : "R2 readback", v, VEC[i][31:0]);
    end
    // R3 nothing active yet
    chk("R3 actives hold before commit", acts(), 32'h0);
    // R5 cfg,N,M dirty; D equal to active stays clean
    rd(5'h00, v); chk("R5 dirty flags", v, 32'h8000_0070);

    // R4 commit and window length
    wr(5'h00, 32'h1);
    poll_upd(c); chk("R4 update window cycles", c, 32'd4);
    // {mode=2,src=3,div=5} {m=34} {n=CD} {d=00} packed
    chk("R4 committed actives", acts(), {2'd2, 3'd3, 5'd5, 8'h34, 8'hCD, 8'h00} >> 0);
    rd(5'h00, v); chk("R5 dirty cleared on commit", v, 32'h8000_0000);

    // R4 write 0 to update bit starts nothing
    wr(5'h08, 32'h55);
    wr(5'h00, 32'h0);
    rd(5'h00, v); chk("R4 zero write no update", v, 32'h8000_0040);
    chk("R3 act_m held", {24'h0, act_m_o}, 32'h34);

    // R4 shadow write inside the commit window
    wr(5'h00, 32'h1);
    wr(5'h08, 32'h99);
    poll_upd(c);
    chk("R4 write in window committed", {24'h0, act_m_o}, 32'h99);
    rd(5'h00, v); chk("R5 clear after window", v, 32'h8000_0000);

    // R8 read-only and reserved command bits
    wr(5'h00, 32'h8000_00F0);
    rd(5'h00, v); chk("R8 reserved cmd bits", v, 32'h8000_0000);

    // R5 equal write keeps flag clear, D flag position
    wr(5'h08, 32'h99);
    rd(5'h00, v); chk("R5 equal write clean", v, 32'h8000_0000);
    wr(5'h10, 32'h01);
    rd(5'h00, v); chk("R5 D dirty bit7", v, 32'h8000_0080);
    wr(5'h00, 32'h1);
    poll_upd(c);
    chk("R4 D committed", {24'h0, act_d_o}, 32'h01);

    // R6 / R7 force enable
    wr(5'h00, 32'h2);
    rd(5'h00, v); chk("R6 force bit set", v, 32'h8000_0002);
    rd(5'h00, v); chk("R7 off after one edge", v, 32'h8000_0002);
    rd(5'h00, v); chk("R7 on after two edges", v, 32'h0000_0002);
    chk("R7 root_on_o", {31'h0, root_on_o}, 32'h1);
    wr(5'h00, 32'h0);
    rd(5'h00, v); rd(5'h00, v);
    rd(5'h00, v); chk("R7 off after force clear", v, 32'h8000_0000);

    // R7 external enable
    ext_en_i = 1'b1;
    @(negedge clk_i);
    chk("R7 ext one edge", {31'h0, root_on_o}, 32'h0);
    @(negedge clk_i);
    chk("R7 ext two edges", {31'h0, root_on_o}, 32'h1);
    ext_en_i = 1'b0;
    repeat (3) @(negedge clk_i);

    // R1 reset from a busy state
    wr(5'h04, 32'h0000_1111);
    do_reset();
    rd(5'h04, v); chk("R1 cfg after second reset", v, 32'h0);
    rd(5'h00, v); chk("R1 cmd after second reset", v, 32'h8000_0000);
    chk("R1 actives after second reset", acts(), 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule